// File: doc/BRIEF.md
# Saturating Float-to-Integer Converter

This block turns one floating-point value per transfer into an integer. The source is either a 16-bit half-precision value, carried in the low half of the source word, or a 32-bit single-precision value. The destination is 8, 16 or 32 bits wide, signed or unsigned. The value is first rounded to an integer under one of five rounding modes. It then goes through a range stage. That stage either clamps the result to the destination limits or wraps it, keeping the low bits. NaN and infinity inputs get fixed treatment. A per-transfer mask bit forces the result to zero.

Saturation is chosen per transfer by a request bit. A two-bit configuration register, written through a plain write-enable port, can override that choice for every transfer. The data path is a valid/ready stream with a single output register, so each result appears one cycle after it is accepted.

Back-pressure rules:
- `in_ready` is high whenever the output register is empty or is being drained in the same cycle.
- While `out_valid` is high and `out_ready` is low, the output holds its value unchanged and no new input is taken.

Top module: `fcvt_sat_top`

## Requirements
- R1: The rounding code on `in_rnd` selects how the value becomes an integer: 0 = nearest with ties to even, 1 = nearest with ties away from zero, 2 = toward minus infinity, 3 = toward plus infinity, 4 = toward zero. Codes 5 to 7 behave as code 4. Negative zero and magnitudes below one follow the same rules, so rounding -0.3 toward minus infinity gives -1.
- R2: The range check applies to the rounded value. For example, 255.5 rounded to nearest-even becomes 256, which is out of range for an unsigned 8-bit destination.
- R3: When not saturating, an out-of-range finite value yields the low destination-width bits of its two's-complement integer. For example, 257.0 to unsigned 8 bits gives 1.
- R4: When saturating, an out-of-range value becomes the nearest destination limit. For example, 257.0 to unsigned 8 bits gives 255, and any value below zero to an unsigned destination gives 0.
- R5: A NaN source gives 0 in both modes.
- R6: An infinite source gives the destination maximum for +inf and the destination minimum for -inf, in both modes.
- R7: When the stored global-enable bit is 0, `in_sat` decides whether the transfer saturates. When it is 1, the stored global-wrap bit decides for all transfers: 1 means wrap and 0 means saturate. A configuration write takes effect for transfers accepted after the write edge.
- R8: A transfer accepted with `in_mask` low produces 0.
- R9: An accepted transfer appears on `out_data` with `out_valid` high after exactly one clock edge. `in_ready` equals not `out_valid` or `out_ready`. The output is held stable while it is stalled.
- R10: `in_single` = 1 reads the source as single precision in bits 31:0. `in_single` = 0 reads it as half precision in bits 15:0. Subnormals are converted exactly. `in_dst_w` = 0 selects 8 bits, 1 selects 16 bits, and 2 or 3 select 32 bits. The result sits in the low bits of `out_data`, sign-extended for a signed destination (`in_dst_signed` = 1) and zero-extended for an unsigned one.
- R11: After reset, `out_valid` is 0, `in_ready` is 1, and both configuration bits are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Loads the two configuration bits |
| cfg_global_en | input | 1 | Configuration value: global mode override enable |
| cfg_global_wrap | input | 1 | Configuration value: 1 = global wrap, 0 = global saturate |
| in_valid | input | 1 | Source transfer valid |
| in_ready | output | 1 | Converter can accept a transfer |
| in_src | input | 32 | Source bits |
| in_single | input | 1 | 1 = single precision, 0 = half precision |
| in_dst_w | input | 2 | Destination width code |
| in_dst_signed | input | 1 | Destination is signed |
| in_rnd | input | 3 | Rounding code |
| in_sat | input | 1 | Per-transfer saturate request |
| in_mask | input | 1 | Lane enable; 0 forces a zero result |
| out_valid | output | 1 | Result valid |
| out_ready | input | 1 | Consumer accepts the result |
| out_data | output | 32 | Converted integer |

## Verification
The bench builds the converter with the package's fixed widths: a 32-bit output word, a 24-bit significand path and a 33-bit rounded magnitude. Within those widths every destination width and both source formats can be exercised, including single-precision values far beyond 2^32, where wrapping must leave only zeros in the low bits.

Random exponents are concentrated around the integer ranges so that rounding carries across limits happen often. Directed cases cover:
- ties in each rounding mode;
- negative fractions;
- infinities and NaN;
- the global override settings;
- a stalled output.

// File: rtl/fcvt_pkg.sv
package fcvt_pkg;
  localparam int OUT_W  = 32;
  localparam int FRAC_W = 23;
  localparam int MANT_W = FRAC_W + 1;
  localparam int GUARD  = MANT_W + 1;
  localparam int MAG_W  = OUT_W + 1;
  localparam int EXP_W  = 10;
  localparam int HFRAC  = 10;
  localparam int WID_W  = $clog2(OUT_W) + 1;

  typedef enum logic [2:0] {
    RND_NEAR_EVEN = 3'd0,
    RND_NEAR_AWAY = 3'd1,
    RND_DOWN      = 3'd2,
    RND_UP        = 3'd3,
    RND_ZERO      = 3'd4
  } rnd_e;

  typedef enum logic [1:0] {
    DW_8  = 2'd0,
    DW_16 = 2'd1,
    DW_32 = 2'd2,
    DW_32B = 2'd3
  } dw_e;

  typedef struct packed {
    logic              sign;
    logic              is_nan;
    logic              is_inf;
    logic [EXP_W-1:0]  exp;
    logic [MANT_W-1:0] mant;
  } unp_t;
endpackage

// File: rtl/fcvt_unpack.sv
module fcvt_unpack
  import fcvt_pkg::*;
(
  input  logic [OUT_W-1:0] src,
  input  logic             is_single,
  output unp_t             u
);
  logic [7:0]        s_e;
  logic [FRAC_W-1:0] s_f;
  logic [4:0]        h_e;
  logic [HFRAC-1:0]  h_f;

  assign s_e = src[30:23];
  assign s_f = src[FRAC_W-1:0];
  assign h_e = src[14:10];
  assign h_f = src[HFRAC-1:0];

  always_comb begin
    u = '0;
    if (is_single) begin
      u.sign   = src[31];
      u.is_nan = (s_e == 8'hFF) && (s_f != '0);
      u.is_inf = (s_e == 8'hFF) && (s_f == '0);
      u.exp    = (s_e == 8'h00) ? EXP_W'(-126) : EXP_W'(int'(s_e) - 127);
      u.mant   = {(s_e != 8'h00), s_f};
    end else begin
      u.sign   = src[15];
      u.is_nan = (h_e == 5'h1F) && (h_f != '0);
      u.is_inf = (h_e == 5'h1F) && (h_f == '0);
      u.exp    = (h_e == 5'h00) ? EXP_W'(-14) : EXP_W'(int'(h_e) - 15);
      u.mant   = {(h_e != 5'h00), h_f, {(FRAC_W-HFRAC){1'b0}}};
    end
  end
endmodule

// File: rtl/fcvt_round.sv
module fcvt_round
  import fcvt_pkg::*;
(
  input  logic              sign,
  input  logic [EXP_W-1:0]  exp,
  input  logic [MANT_W-1:0] mant,
  input  rnd_e              rm,
  output logic [MAG_W-1:0]  mag,
  output logic              huge
);
  int                       ex;
  int                       sh;
  logic [MANT_W+GUARD-1:0]  ext;
  logic [MANT_W-1:0]        ipart;
  logic                     rbit;
  logic                     sticky;
  logic                     inc;

  always_comb begin
    ex     = int'($signed(exp));
    sh     = 0;
    mag    = '0;
    huge   = 1'b0;
    ext    = '0;
    ipart  = '0;
    rbit   = 1'b0;
    sticky = 1'b0;
    inc    = 1'b0;
    if (ex >= FRAC_W) begin
      // integral value: shift left, keep low MAG_W bits for wrapping
      sh   = ex - FRAC_W;
      mag  = MAG_W'(mant) << sh;
      huge = (ex >= OUT_W);
    end else begin
      sh = FRAC_W - ex;
      if (sh <= GUARD) begin
        ext    = {mant, {GUARD{1'b0}}} >> sh;
        sticky = |ext[GUARD-2:0];
      end else begin
        sticky = |mant;
      end
      ipart = ext[MANT_W+GUARD-1:GUARD];
      rbit  = ext[GUARD-1];
      case (rm)
        RND_NEAR_EVEN: inc = rbit & (sticky | ipart[0]);
        RND_NEAR_AWAY: inc = rbit;
        RND_DOWN:      inc = sign & (rbit | sticky);
        RND_UP:        inc = ~sign & (rbit | sticky);
        default:       inc = 1'b0;
      endcase
      mag = MAG_W'(ipart) + MAG_W'(inc);
    end
  end
endmodule

// File: rtl/fcvt_range.sv
module fcvt_range
  import fcvt_pkg::*;
(
  input  logic             sign,
  input  logic             is_nan,
  input  logic             is_inf,
  input  logic [MAG_W-1:0] mag,
  input  logic             huge,
  input  dw_e              dw,
  input  logic             is_signed,
  input  logic             saturate,
  output logic [OUT_W-1:0] res
);
  logic [WID_W-1:0] wid;
  logic [MAG_W-1:0] lim_pos;
  logic [MAG_W-1:0] lim_neg;
  logic             in_range;
  logic [OUT_W-1:0] wrapped;
  logic [OUT_W-1:0] clamped;
  logic [OUT_W-1:0] raw;
  logic             top_bit;

  always_comb begin
    case (dw)
      DW_8:    wid = WID_W'(8);
      DW_16:   wid = WID_W'(16);
      default: wid = WID_W'(OUT_W);
    endcase
    lim_pos  = is_signed ? ((MAG_W'(1) << (wid - 1'b1)) - MAG_W'(1))
                         : ((MAG_W'(1) << wid) - MAG_W'(1));
    lim_neg  = is_signed ? (MAG_W'(1) << (wid - 1'b1)) : '0;
    in_range = !huge && (sign ? (mag <= lim_neg) : (mag <= lim_pos));
    wrapped  = sign ? (OUT_W'(0) - mag[OUT_W-1:0]) : mag[OUT_W-1:0];
    clamped  = sign ? (OUT_W'(0) - lim_neg[OUT_W-1:0]) : lim_pos[OUT_W-1:0];
    if (is_nan)        raw = '0;
    else if (is_inf)   raw = clamped;
    else if (in_range) raw = wrapped;
    else if (saturate) raw = clamped;
    else               raw = wrapped;
    top_bit = is_signed & raw[wid - 1'b1];
  end

  for (genvar i = 0; i < OUT_W; i++) begin : g_ext
    assign res[i] = (i < int'(wid)) ? raw[i] : top_bit;
  end
endmodule

// File: rtl/fcvt_sat_top.sv
module fcvt_sat_top
  import fcvt_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic             cfg_global_en,
  input  logic             cfg_global_wrap,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [OUT_W-1:0] in_src,
  input  logic             in_single,
  input  logic [1:0]       in_dst_w,
  input  logic             in_dst_signed,
  input  logic [2:0]       in_rnd,
  input  logic             in_sat,
  input  logic             in_mask,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [OUT_W-1:0] out_data
);
  logic             cfg_en_q;
  logic             cfg_wrap_q;
  logic             eff_sat;
  unp_t             u;
  logic [MAG_W-1:0] mag;
  logic             huge;
  logic [OUT_W-1:0] res_c;
  logic             accept;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_en_q   <= 1'b0;
      cfg_wrap_q <= 1'b0;
    end else if (cfg_we) begin
      cfg_en_q   <= cfg_global_en;
      cfg_wrap_q <= cfg_global_wrap;
    end
  end

  assign eff_sat = cfg_en_q ? !cfg_wrap_q : in_sat;

  fcvt_unpack u_unpack (
    .src       (in_src),
    .is_single (in_single),
    .u         (u)
  );

  fcvt_round u_round (
    .sign (u.sign),
    .exp  (u.exp),
    .mant (u.mant),
    .rm   (rnd_e'(in_rnd)),
    .mag  (mag),
    .huge (huge)
  );

  fcvt_range u_range (
    .sign      (u.sign),
    .is_nan    (u.is_nan),
    .is_inf    (u.is_inf),
    .mag       (mag),
    .huge      (huge),
    .dw        (dw_e'(in_dst_w)),
    .is_signed (in_dst_signed),
    .saturate  (eff_sat),
    .res       (res_c)
  );

  assign in_ready = !out_valid || out_ready;
  assign accept   = in_valid && in_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else if (accept) begin
      out_valid <= 1'b1;
      out_data  <= in_mask ? res_c : '0;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end

  assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data));

  assert_latency_R9: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> out_valid);

  assert_zero_mask_R8: assert property (@(posedge clk) disable iff (!rst_n)
    accept && !in_mask |=> out_data == '0);

  assert_nan_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
    accept && in_mask && u.is_nan |=> out_data == '0);

  assert_unsigned_floor_R4: assert property (@(posedge clk) disable iff (!rst_n)
    accept && in_mask && eff_sat && !in_dst_signed && u.sign && !u.is_nan
      && ((mag != '0) || huge) |=> out_data == '0);

  assert_pos_inf_u8_R6: assert property (@(posedge clk) disable iff (!rst_n)
    accept && in_mask && u.is_inf && !u.sign && (in_dst_w == 2'd0) && !in_dst_signed
      |=> out_data == 32'h0000_00FF);
endmodule

// File: tb/fcvt_sat_top_test.sv
`timescale 1ns/1ps
module fcvt_sat_top_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0, cfg_global_en = 1'b0, cfg_global_wrap = 1'b0;
  logic        in_valid = 1'b0, in_ready;
  logic [31:0] in_src = '0;
  logic        in_single = 1'b1;
  logic [1:0]  in_dst_w = '0;
  logic        in_dst_signed = 1'b0;
  logic [2:0]  in_rnd = '0;
  logic        in_sat = 1'b0, in_mask = 1'b1;
  logic        out_valid, out_ready = 1'b1;
  logic [31:0] out_data;

  int checks = 0, errors = 0;
  bit done = 0;
  bit m_en = 0, m_wrap = 0;

  always #2 clk = ~clk;

  fcvt_sat_top uut (.*);

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic real f_val(input logic [31:0] b, input bit sgl, output bit nan, output bit inf);
    real v;
    int e, f;
    nan = 0; inf = 0;
    if (sgl) begin
      e = int'(b[30:23]); f = int'(b[22:0]);
      if (e == 255) begin nan = (f != 0); inf = (f == 0); v = 0.0; end
      else if (e == 0) v = real'(f) * (2.0 ** (-149));
      else v = real'(f + 8388608) * (2.0 ** (e - 150));
      return b[31] ? -v : v;
    end else begin
      e = int'(b[14:10]); f = int'(b[9:0]);
      if (e == 31) begin nan = (f != 0); inf = (f == 0); v = 0.0; end
      else if (e == 0) v = real'(f) * (2.0 ** (-24));
      else v = real'(f + 1024) * (2.0 ** (e - 25));
      return b[15] ? -v : v;
    end
  endfunction

  function automatic logic [31:0] s_bits(input real v);
    real m;
    int e;
    longint fr;
    bit s;
    if (v == 0.0) return 32'h0;
    s = v < 0.0; m = s ? -v : v; e = 0;
    while (m >= 2.0) begin m = m / 2.0; e++; end
    while (m < 1.0) begin m = m * 2.0; e--; end
    fr = longint'((m - 1.0) * 8388608.0);
    return {s, 8'(e + 127), fr[22:0]};
  endfunction

  function automatic real rnd_ref(input real v, input int rm);
    real f, d;
    if (v == $floor(v)) return v;
    f = $floor(v); d = v - f;
    case (rm)
      0: return (d > 0.5) ? f + 1.0 : (d < 0.5) ? f : (($floor(f / 2.0) * 2.0 == f) ? f : f + 1.0);
      1: return (d > 0.5) ? f + 1.0 : (d < 0.5) ? f : ((v > 0.0) ? f + 1.0 : f);
      2: return f;
      3: return f + 1.0;
      default: return (v > 0.0) ? f : f + 1.0;
    endcase
  endfunction

  function automatic logic [31:0] ext_ref(input logic [31:0] b, input int w, input bit sgn);
    logic [31:0] r;
    for (int i = 0; i < 32; i++) r[i] = (i < w) ? b[i] : (sgn & b[w-1]);
    return r;
  endfunction

  function automatic logic [31:0] conv_ref(input logic [31:0] src, input bit sgl, input bit [1:0] dw,
                                           input bit sgn, input bit [2:0] rm, input bit sat, input bit msk);
    bit nan, inf;
    real v, r, lo, hi;
    int w;
    longint li;
    if (!msk) return 32'h0;
    v = f_val(src, sgl, nan, inf);
    w = (dw == 0) ? 8 : (dw == 1) ? 16 : 32;
    lo = sgn ? -(2.0 ** (w - 1)) : 0.0;
    hi = sgn ? (2.0 ** (w - 1)) - 1.0 : (2.0 ** w) - 1.0;
    if (nan) return 32'h0;
    if (inf) r = (v < 0.0 || (sgl ? src[31] : src[15])) ? lo : hi;
    else begin
      r = rnd_ref(v, int'(rm));
      if ((r < lo || r > hi) && sat) r = (r < lo) ? lo : hi;
    end
    if (r >= 1152921504606846976.0 || r <= -1152921504606846976.0) li = 0;
    else li = longint'(r);
    return ext_ref(li[31:0], w, sgn);
  endfunction

  task automatic xfer(input logic [31:0] src, input bit sgl, input bit [1:0] dw, input bit sgn,
                      input bit [2:0] rm, input bit sat, input bit msk, input string req,
                      input bit use_lit, input logic [31:0] lit);
    logic [31:0] e;
    @(negedge clk);
    in_src = src; in_single = sgl; in_dst_w = dw; in_dst_signed = sgn;
    in_rnd = rm; in_sat = sat; in_mask = msk; in_valid = 1'b1; out_ready = 1'b1;
    @(posedge clk); #1 in_valid = 1'b0;
    @(negedge clk);
    e = conv_ref(src, sgl, dw, sgn, rm, m_en ? !m_wrap : sat, msk);
    check({req, " valid"}, {31'b0, out_valid}, 32'd1);
    check(req, out_data, e);
    if (use_lit) check({req, " literal"}, out_data, lit);
  endtask

  task automatic cfg(input bit en, input bit wrap);
    @(negedge clk);
    cfg_we = 1'b1; cfg_global_en = en; cfg_global_wrap = wrap;
    @(posedge clk); #1 cfg_we = 1'b0;
    m_en = en; m_wrap = wrap;
  endtask

  initial begin
    #800000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] a, b, ea, eb;
    void'($urandom(32'd1234));
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    check("R11 out_valid after reset", {31'b0, out_valid}, 32'd0);
    check("R11 in_ready after reset", {31'b0, in_ready}, 32'd1);
    // R11 configuration bits at zero: per-transfer request must rule
    xfer(s_bits(257.0), 1, 0, 0, 4, 0, 1, "R11 cfg clear wrap", 1, 32'd1);

    xfer(s_bits(257.0), 1, 0, 0, 4, 0, 1, "R3 wrap 257 u8", 1, 32'd1);
    xfer(s_bits(257.0), 1, 0, 0, 4, 1, 1, "R4 clamp 257 u8", 1, 32'd255);
    xfer(s_bits(-5.0), 1, 0, 0, 4, 1, 1, "R4 negative to u8", 1, 32'd0);
    xfer(32'hFF80_0000, 1, 0, 0, 0, 1, 1, "R6 -inf u8", 1, 32'd0);
    xfer(32'hFF80_0000, 1, 1, 1, 0, 0, 1, "R6 -inf s16 wrap", 1, 32'hFFFF_8000);
    xfer(32'h7F80_0000, 1, 0, 1, 0, 0, 1, "R6 +inf s8 wrap", 1, 32'd127);
    xfer(32'h7FC0_0001, 1, 2, 1, 0, 1, 1, "R5 nan sat", 1, 32'd0);
    xfer(32'h0000_7E01, 0, 2, 1, 0, 0, 1, "R5 half nan wrap", 1, 32'd0);
    xfer(s_bits(-0.3), 1, 0, 1, 2, 1, 1, "R1 floor -0.3 s8", 1, 32'hFFFF_FFFF);
    xfer(s_bits(-0.3), 1, 0, 0, 2, 1, 1, "R4 floor -0.3 u8", 1, 32'd0);
    xfer(32'h8000_0000, 1, 0, 1, 2, 1, 1, "R1 floor -0.0", 1, 32'd0);
    xfer(s_bits(2.5), 1, 2, 1, 0, 1, 1, "R1 even tie 2.5", 1, 32'd2);
    xfer(s_bits(2.5), 1, 2, 1, 1, 1, 1, "R1 away tie 2.5", 1, 32'd3);
    xfer(s_bits(-2.5), 1, 2, 1, 1, 1, 1, "R1 away tie -2.5", 1, 32'hFFFF_FFFD);
    xfer(s_bits(-2.5), 1, 2, 1, 3, 1, 1, "R1 ceil -2.5", 1, 32'hFFFF_FFFE);
    xfer(s_bits(-2.5), 1, 2, 1, 4, 1, 1, "R1 trunc -2.5", 1, 32'hFFFF_FFFE);
    xfer(s_bits(2.7), 1, 2, 1, 6, 1, 1, "R1 code 6 truncates", 1, 32'd2);
    xfer(s_bits(255.5), 1, 0, 0, 0, 1, 1, "R2 255.5 even sat", 1, 32'd255);
    xfer(s_bits(255.5), 1, 0, 0, 0, 0, 1, "R2 255.5 even wrap", 1, 32'd0);
    xfer(s_bits(3000000000.0), 1, 2, 1, 4, 0, 1, "R3 3e9 s32 wrap", 1, 32'hB2D0_5E00);
    xfer(s_bits(3000000000.0), 1, 2, 1, 4, 1, 1, "R4 3e9 s32 sat", 1, 32'h7FFF_FFFF);
    xfer(s_bits(3000000000.0), 1, 3, 0, 4, 0, 1, "R10 3e9 u32", 1, 32'hB2D0_5E00);
    xfer(32'h0000_5C04, 0, 0, 0, 4, 0, 1, "R10 half 257 u8 wrap", 1, 32'd1);
    xfer(32'h0000_0001, 0, 0, 0, 3, 1, 1, "R10 half subnormal ceil", 1, 32'd1);
    xfer(s_bits(-100.0), 1, 1, 0, 4, 0, 1, "R10 -100 u16 wrap zero-ext", 1, 32'h0000_FF9C);
    xfer(s_bits(257.0), 1, 0, 0, 4, 1, 0, "R8 masked lane", 1, 32'd0);

    cfg(1, 1);
    xfer(s_bits(257.0), 1, 0, 0, 4, 1, 1, "R7 global wrap overrides", 1, 32'd1);
    cfg(1, 0);
    xfer(s_bits(257.0), 1, 0, 0, 4, 0, 1, "R7 global sat overrides", 1, 32'd255);
    cfg(0, 1);
    xfer(s_bits(257.0), 1, 0, 0, 4, 0, 1, "R7 per-transfer wrap", 1, 32'd1);

    // R9 stall: hold the output, then release with a second transfer waiting
    a = s_bits(300.0); b = s_bits(-7.0);
    ea = 32'd255; eb = 32'hFFFF_FFF9;
    @(negedge clk);
    in_src = a; in_single = 1; in_dst_w = 0; in_dst_signed = 0; in_rnd = 4;
    in_sat = 1; in_mask = 1; in_valid = 1; out_ready = 0;
    @(posedge clk); #1 in_src = b; in_dst_w = 2; in_dst_signed = 1;
    @(negedge clk);
    check("R9 stalled valid", {31'b0, out_valid}, 32'd1);
    check("R9 stalled in_ready", {31'b0, in_ready}, 32'd0);
    check("R9 first data", out_data, ea);
    @(negedge clk);
    check("R9 held data", out_data, ea);
    out_ready = 1;
    @(posedge clk); #1 in_valid = 0;
    @(negedge clk);
    check("R9 second data", out_data, eb);
    check("R9 second valid", {31'b0, out_valid}, 32'd1);

    for (int n = 0; n < 600; n++) begin
      logic [31:0] s;
      bit sgl;
      int sel;
      sel = int'($urandom % 10);
      sgl = $urandom % 2;
      if (n % 97 == 0) cfg($urandom % 2, $urandom % 2);
      if (sgl) begin
        if (sel == 0) s = $urandom;
        else s = {1'($urandom), 8'(120 + $urandom % 45), 23'($urandom)};
      end else begin
        s = {16'($urandom), 16'($urandom)};
      end
      xfer(s, sgl, 2'($urandom), 1'($urandom), 3'($urandom), 1'($urandom),
           ($urandom % 8) != 0, "R1 R2 R3 R4 R10 random", 0, 32'd0);
    end

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule